// File: doc/BRIEF.md
# Serial Pattern Unlock Sequencer

This block sits beside a memory device and watches its chip-enable, output-enable and write-enable strobes, together with a one-bit data input and a one-bit data output. It takes up no address space. A read cycle arms a hidden 64-bit key matcher. The key must then arrive as 64 consecutive single-bit write cycles. Until the key has matched, every access belongs to the memory. Once the key matches, the block claims the bus and raises a flag that the chip-enable gating logic uses to shut the memory out. It then moves the eight 8-bit clock registers serially, one bit per bus cycle.

In a read transfer, each read cycle returns the next bit of a snapshot of the clock registers. The snapshot is taken at the moment of unlock. In a write transfer, each write cycle shifts in one bit. The clock core receives one load strobe for each complete 8-bit register. Once 64 transfer cycles have run, the block drops ownership and needs a fresh unlock. An external reset pin can cut a transfer short, and a register bit held by the clock core decides whether that pin is honoured.

Top module: `ucs_top`

## Requirements
- R1: After synchronous reset, `bus_own`, `load_valid` and `bus_dout` are low and the matcher is disarmed.
- R2: While the matcher is disarmed, write cycles never advance it, so a key written with no read before it never unlocks the block.
- R3: A read cycle arms the matcher. 64 write cycles that follow, each matching the next key bit, raise `bus_own` from the cycle after the clock edge on which the 64th write is seen. The key is the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C, taken least-significant bit first within each byte.
- R4: A write whose data bit differs from the expected key bit disarms the matcher. Later writes are then ignored until the next read cycle.
- R5: A read cycle during matching returns the pointer to the first key bit, so the key has to be written again in full.
- R6: In a read transfer, the n-th transfer cycle (n = 0..63) drives bit n of the snapshot onto `bus_dout`. Bit b of register k is bit 8k+b. The value is valid from the cycle after the read is seen and is held until the next read.
- R7: The snapshot is captured from `clk_regs` on the unlock edge. Later changes to `clk_regs` do not change the bits read out.
- R8: In a write transfer, bits are collected least-significant bit first. When all 8 cycles of register k were writes, the 8th of them produces a single-cycle `load_valid` carrying `load_idx` = k and the assembled byte on `load_data`.
- R9: Once the 64th transfer cycle has run, `bus_own` goes low and the matcher is disarmed. Further access needs another read and a full key.
- R10: A cycle counts once, on the rise of (ce and oe) for a read or of (ce and we and not oe) for a write. Strobes while `bus_ce` is low are ignored and leave any match or transfer in progress undisturbed.
- R11: While `rst_en` is 0, a low on `rst_pin_n` aborts at once: `bus_own` falls, the matcher disarms, and no load is issued for the register that was only partly written.
- R12: While `rst_en` is 1, `rst_pin_n` has no effect and the transfer runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce | input | 1 | Chip enable of the shared memory slot, active high |
| bus_oe | input | 1 | Output enable, active high; a rise with ce marks a read cycle |
| bus_we | input | 1 | Write enable, active high; a rise with ce and no oe marks a write cycle |
| bus_din | input | 1 | Serial data bit of a write cycle |
| rst_pin_n | input | 1 | External abort, active low |
| rst_en | input | 1 | Reset-pin mask from the clock core; 1 ignores `rst_pin_n` |
| clk_regs | input | NREG*RW | Current clock register contents, register 0 in the low byte |
| bus_dout | output | 1 | Serial data bit returned by read transfer cycles |
| bus_own | output | 1 | High while the block owns the bus; used to disable the memory |
| load_valid | output | 1 | One-cycle strobe: commit one register to the clock core |
| load_idx | output | $clog2(NREG) | Index of the register being committed |
| load_data | output | RW | Byte to commit |

## Verification
On every cycle the assertions check several things. Ownership can only begin on a write cycle. A mismatching key bit disarms the matcher. A read during matching rewinds the pointer. The pointer stays put on cycles with no event. Loads only come out while the block owns the bus. An honoured abort clears ownership, arming and any pending load. The bench scenarios are the only way to show the exact key bit order, the mapping from bit position to register, the coherence of the snapshot, interleaving with foreign cycles, and that the reset pin is ignored when masked.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  // Key bytes C5,3A,A3,5C twice; byte 0 in the low bits, consumed LSB first.
  localparam logic [63:0] UCS_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

  typedef enum logic {ST_HUNT = 1'b0, ST_XFER = 1'b1} ucs_state_e;
endpackage

// File: rtl/ucs_cycle_detect.sv
module ucs_cycle_detect (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic oe,
  input  logic we,
  output logic rd_evt,
  output logic wr_evt
);
  logic rd_lvl, wr_lvl;
  logic rd_prev, wr_prev;

  assign rd_lvl = ce & oe;
  assign wr_lvl = ce & we & ~oe;
  assign rd_evt = rd_lvl & ~rd_prev;
  assign wr_evt = wr_lvl & ~wr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      rd_prev <= rd_lvl;
      wr_prev <= wr_lvl;
    end
  end
endmodule

// File: rtl/ucs_key_matcher.sv
module ucs_key_matcher #(
  parameter int unsigned KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY = ucs_pkg::UCS_KEY,
  localparam int unsigned PTR_W = $clog2(KEY_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hunt,
  input  logic             rd_evt,
  input  logic             wr_evt,
  input  logic             din,
  input  logic             abort,
  input  logic             disarm,
  output logic             unlock,
  output logic             armed,
  output logic [PTR_W-1:0] ptr,
  output logic             key_bit
);
  logic last, hit;

  assign key_bit = KEY[ptr];
  assign last    = (ptr == PTR_W'(KEY_W - 1));
  assign hit     = hunt && armed && wr_evt && !abort && (din == key_bit);
  assign unlock  = hit && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      armed <= 1'b0;
    end else if (abort || disarm) begin
      ptr   <= '0;
      armed <= 1'b0;
    end else if (hunt) begin
      if (rd_evt) begin
        ptr   <= '0;
        armed <= 1'b1;
      end else if (wr_evt && armed) begin
        if (hit) begin
          if (last) begin
            ptr   <= '0;
            armed <= 1'b0;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end else begin
          armed <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ucs_xfer_engine.sv
module ucs_xfer_engine #(
  parameter int unsigned NREG = 8,
  parameter int unsigned RW   = 8,
  localparam int unsigned XB    = NREG * RW,
  localparam int unsigned CNT_W = $clog2(XB),
  localparam int unsigned BIT_W = $clog2(RW),
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             start,
  input  logic             abort,
  input  logic             rd_evt,
  input  logic             wr_evt,
  input  logic             din,
  input  logic [XB-1:0]    reg_in,
  output logic             dout,
  output logic             load_valid,
  output logic [IDX_W-1:0] load_idx,
  output logic [RW-1:0]    load_data,
  output logic             done
);
  logic [XB-1:0]    snap_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RW-1:0]    wbyte_q;
  logic             allw_q;
  logic             step, allw_in;
  logic [BIT_W-1:0] pos;
  logic [RW-1:0]    byte_next;

  assign step      = active && (rd_evt || wr_evt) && !abort;
  assign pos       = cnt_q[BIT_W-1:0];
  assign allw_in   = (pos == '0) ? 1'b1 : allw_q;
  assign byte_next = {din, wbyte_q[RW-1:1]};
  assign done      = step && (cnt_q == CNT_W'(XB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q     <= '0;
      cnt_q      <= '0;
      wbyte_q    <= '0;
      allw_q     <= 1'b1;
      dout       <= 1'b0;
      load_valid <= 1'b0;
      load_idx   <= '0;
      load_data  <= '0;
    end else begin
      load_valid <= 1'b0;
      if (start) begin
        snap_q <= reg_in;
        cnt_q  <= '0;
        allw_q <= 1'b1;
      end else if (abort) begin
        cnt_q  <= '0;
        allw_q <= 1'b1;
      end else if (step) begin
        cnt_q  <= done ? '0 : cnt_q + 1'b1;
        snap_q <= {1'b0, snap_q[XB-1:1]};
        allw_q <= allw_in & ~rd_evt;
        if (rd_evt) begin
          dout <= snap_q[0];
        end else begin
          wbyte_q <= byte_next;
          if (pos == BIT_W'(RW - 1) && allw_in) begin
            load_valid <= 1'b1;
            load_idx   <= cnt_q[CNT_W-1:BIT_W];
            load_data  <= byte_next;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ucs_top.sv
module ucs_top #(
  parameter int unsigned KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY = ucs_pkg::UCS_KEY,
  parameter int unsigned NREG = 8,
  parameter int unsigned RW   = 8,
  localparam int unsigned XB    = NREG * RW,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned PTR_W = $clog2(KEY_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_ce,
  input  logic             bus_oe,
  input  logic             bus_we,
  input  logic             bus_din,
  input  logic             rst_pin_n,
  input  logic             rst_en,
  input  logic [XB-1:0]    clk_regs,
  output logic             bus_dout,
  output logic             bus_own,
  output logic             load_valid,
  output logic [IDX_W-1:0] load_idx,
  output logic [RW-1:0]    load_data
);
  import ucs_pkg::*;

  ucs_state_e       state_q;
  logic             rd_evt, wr_evt;
  logic             abort, unlock, done, armed, key_bit;
  logic [PTR_W-1:0] ptr;

  assign abort   = !rst_pin_n && !rst_en;
  assign bus_own = (state_q == ST_XFER);

  ucs_cycle_detect u_detect (
    .clk    (clk),
    .rst    (rst),
    .ce     (bus_ce),
    .oe     (bus_oe),
    .we     (bus_we),
    .rd_evt (rd_evt),
    .wr_evt (wr_evt)
  );

  ucs_key_matcher #(.KEY_W(KEY_W), .KEY(KEY)) u_match (
    .clk     (clk),
    .rst     (rst),
    .hunt    (state_q == ST_HUNT),
    .rd_evt  (rd_evt),
    .wr_evt  (wr_evt),
    .din     (bus_din),
    .abort   (abort),
    .disarm  (done),
    .unlock  (unlock),
    .armed   (armed),
    .ptr     (ptr),
    .key_bit (key_bit)
  );

  ucs_xfer_engine #(.NREG(NREG), .RW(RW)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .active     (state_q == ST_XFER),
    .start      (unlock),
    .abort      (abort),
    .rd_evt     (rd_evt),
    .wr_evt     (wr_evt),
    .din        (bus_din),
    .reg_in     (clk_regs),
    .dout       (bus_dout),
    .load_valid (load_valid),
    .load_idx   (load_idx),
    .load_data  (load_data),
    .done       (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
    end else if (abort || done) begin
      state_q <= ST_HUNT;
    end else if (unlock) begin
      state_q <= ST_XFER;
    end
  end
endmodule

// File: rtl/ucs_checker.sv
module ucs_checker #(
  parameter int unsigned PTR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_evt,
  input logic             wr_evt,
  input logic             bus_din,
  input logic             bus_own,
  input logic             armed,
  input logic [PTR_W-1:0] ptr,
  input logic             key_bit,
  input logic             load_valid,
  input logic             abort
);
  assert_own_starts_on_write_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_own) |-> $past(wr_evt));

  assert_mismatch_disarms_R4: assert property (@(posedge clk) disable iff (rst)
    (!bus_own && armed && wr_evt && !abort && (bus_din != key_bit)) |=> !armed);

  assert_read_rewinds_R5: assert property (@(posedge clk) disable iff (rst)
    (!bus_own && rd_evt && !abort) |=> (armed && ptr == '0));

  assert_idle_ptr_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!bus_own && !rd_evt && !wr_evt && !abort) |=> $stable(ptr));

  assert_load_only_owned_R8: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> $past(bus_own));

  assert_abort_clears_R11: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!bus_own && !armed && !load_valid));
endmodule

bind ucs_top ucs_checker #(.PTR_W(PTR_W)) u_ucs_checker (
  .clk        (clk),
  .rst        (rst),
  .rd_evt     (rd_evt),
  .wr_evt     (wr_evt),
  .bus_din    (bus_din),
  .bus_own    (bus_own),
  .armed      (armed),
  .ptr        (ptr),
  .key_bit    (key_bit),
  .load_valid (load_valid),
  .abort      (abort)
);

// File: tb/ucs_top_tb.sv
module ucs_top_tb;
  localparam logic [63:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_ce = 0, bus_oe = 0, bus_we = 0, bus_din = 0;
  logic rst_pin_n = 1, rst_en = 0;
  logic [63:0] clk_regs = '0;
  logic bus_dout, bus_own, load_valid;
  logic [2:0] load_idx;
  logic [7:0] load_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [10:0] exp_q[$];

  always #4 clk = ~clk;

  ucs_top u_dut (
    .clk(clk), .rst(rst), .bus_ce(bus_ce), .bus_oe(bus_oe), .bus_we(bus_we),
    .bus_din(bus_din), .rst_pin_n(rst_pin_n), .rst_en(rst_en), .clk_regs(clk_regs),
    .bus_dout(bus_dout), .bus_own(bus_own), .load_valid(load_valid),
    .load_idx(load_idx), .load_data(load_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every load strobe must match the oldest expected item.
  always @(negedge clk) begin
    if (!rst && load_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected load", {53'd0, load_idx, load_data}, 64'd0);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        check({load_idx, load_data} == e, "R8 load item", {53'd0, load_idx, load_data}, {53'd0, e});
      end
    end
  end

  task automatic bus_write(input logic b);
    @(negedge clk); bus_ce = 1; bus_we = 1; bus_din = b;
    @(negedge clk); bus_ce = 0; bus_we = 0;
  endtask

  task automatic bus_read(output logic b);
    @(negedge clk); bus_ce = 1; bus_oe = 1;
    @(negedge clk); b = bus_dout; bus_ce = 0; bus_oe = 0;
  endtask

  task automatic foreign_cycle();
    @(negedge clk); bus_we = 1; bus_oe = 0; bus_din = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic unlock_seq();
    logic d;
    bus_read(d);
    for (int i = 0; i < 64; i++) bus_write(KEY[i]);
  endtask

  task automatic write_pattern(input logic [63:0] p, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      if (i % 8 == 7) exp_q.push_back({3'(i / 8), p[i-7 +: 8]});
      bus_write(p[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic d;
    logic [63:0] pa, pb, got;
    pa = 64'hDEAD_BEEF_0123_A5C3;
    pb = 64'h1357_9BDF_2468_ACE0;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(bus_own == 0, "R1 own after reset", bus_own, 0);
    check(load_valid == 0, "R1 load after reset", load_valid, 0);
    check(bus_dout == 0, "R1 dout after reset", bus_dout, 0);

    // R2 key without a leading read
    for (int i = 0; i < 64; i++) bus_write(KEY[i]);
    check(bus_own == 0, "R2 no unlock without read", bus_own, 0);

    // R4 one wrong bit, then the rest correct
    bus_read(d);
    for (int i = 0; i < 64; i++) bus_write(i == 10 ? ~KEY[i] : KEY[i]);
    check(bus_own == 0, "R4 mismatch blocks unlock", bus_own, 0);

    // R5 read in the middle rewinds the pointer
    bus_read(d);
    for (int i = 0; i < 30; i++) bus_write(KEY[i]);
    bus_read(d);
    for (int i = 30; i < 64; i++) bus_write(KEY[i]);
    check(bus_own == 0, "R5 tail after rewind rejected", bus_own, 0);

    // R3 full unlock
    clk_regs = pa;
    unlock_seq();
    check(bus_own == 1, "R3 unlock", bus_own, 1);

    // R6/R7 read transfer, with clk_regs changed after unlock
    clk_regs = ~pa;
    got = '0;
    for (int i = 0; i < 64; i++) begin
      bus_read(d);
      got[i] = d;
      if (i == 5) check(d == pa[5], "R6 bit 5 held", d, pa[5]);
    end
    check(got == pa, "R6 R7 snapshot readout", got, pa);
    check(bus_own == 0, "R9 own drops after 64", bus_own, 0);
    // R9 fresh unlock needed: key without read
    for (int i = 0; i < 64; i++) bus_write(KEY[i]);
    check(bus_own == 0, "R9 no reuse", bus_own, 0);

    // R8 write transfer
    unlock_seq();
    write_pattern(pb, 0, 64);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R8 all loads seen", exp_q.size(), 0);
    check(bus_own == 0, "R9 own drops after write transfer", bus_own, 0);

    // R10 interleaved foreign cycles and held strobes
    bus_read(d);
    for (int i = 0; i < 64; i++) begin
      bus_write(KEY[i]);
      foreign_cycle();
    end
    check(bus_own == 1, "R10 unlock with foreign cycles", bus_own, 1);
    @(negedge clk); bus_ce = 1; bus_oe = 1;
    repeat (4) @(negedge clk);
    bus_ce = 0; bus_oe = 0;
    for (int i = 1; i < 64; i++) bus_read(d);
    check(bus_own == 0, "R10 held read counted once", bus_own, 0);

    // R11 abort honoured
    rst_en = 0;
    unlock_seq();
    write_pattern(pb, 0, 12);
    @(negedge clk); rst_pin_n = 0;
    @(negedge clk); rst_pin_n = 1;
    check(bus_own == 0, "R11 abort drops own", bus_own, 0);
    for (int i = 12; i < 16; i++) bus_write(pb[i]);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R11 no partial load", exp_q.size(), 0);

    // R12 reset pin masked
    rst_en = 1;
    unlock_seq();
    write_pattern(~pb, 0, 8);
    @(negedge clk); rst_pin_n = 0;
    @(negedge clk); rst_pin_n = 1;
    check(bus_own == 1, "R12 masked pin ignored", bus_own, 1);
    write_pattern(~pb, 8, 64);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R12 all loads after masked pin", exp_q.size(), 0);
    check(bus_own == 0, "R12 transfer completed", bus_own, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule